// File: doc/BRIEF.md
# Fan PWM Generator with Selectable Rate

This block drives a fan speed control pin with a pulse-width modulated waveform of 64 steps per period. A 6-bit duty count sets how many of the 64 steps the pin is high. The duty cycle is therefore count/64, and a count of zero holds the pin low. A separate force input overrides everything and holds the pin high.

Three mode inputs pick one of eight PWM rates. The source bit chooses a fast (kHz) or a slow (tens of Hz) range. The select bit chooses the base rate or 1.5 times it. The multiplier bit doubles the result. A prescaler on the reference clock produces a step enable, and a 6-bit step counter wraps once per period. The four base step dividers are parameters, so the period in reference cycles is exact and known.

A new duty count or new mode bits are captured only when the step counter wraps. A change in the middle of a period therefore cannot cut a pulse short or stretch it.

Top module: `fan_pwm`

## Requirements
- R1: While reset is asserted and after reset is released, with force low, the output is low until a non-zero duty count has been captured.
- R2: With force low and a captured duty count of 0, the output stays low for the whole period.
- R3: With a captured duty count N from 1 to 63, the output is high for N*D reference cycles at the start of each period and low for the rest, where D is the step divider of the active mode.
- R4: Each period lasts exactly 64*D reference cycles.
- R5: With the multiplier bit at 0, D is 2*FAST_A for source 0/select 0, 2*FAST_B for source 0/select 1, 2*SLOW_A for source 1/select 0 and 2*SLOW_B for source 1/select 1.
- R6: With the multiplier bit at 1, D is half of its value in R5, which doubles the PWM frequency.
- R7: Changes to the duty count and to the mode bits take effect only at the next period boundary. A change in the middle of a period leaves the current pulse unchanged.
- R8: When force is 1, the output is high in the same cycle, whatever the duty count and mode bits are. When force returns to 0, the normal waveform resumes at once.
- R9: A duty count of 63 leaves exactly one step (D cycles) low per period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous reset, active low |
| force_i | input | 1 | Hold output high (100% duty) |
| mult_i | input | 1 | Double the selected PWM rate |
| src_i | input | 1 | Range select: 0 fast, 1 slow |
| sel_i | input | 1 | Base rate (0) or 1.5 times base (1) |
| duty_i | input | 6 | Duty count, high steps per 64-step period |
| pwm_o | output | 1 | Fan control pin level |

## Verification
The embedded assertions check on every cycle that:
- the step counter advances by one only on a prescaler enable;
- the prescaler stays below the active divider;
- the captured settings change only at a wrap;
- force always yields a high pin;
- a zero duty count yields a low pin.

Only the bench's scenarios can show the end-to-end behaviour: the exact high time and period in reference cycles for all eight modes, the 63-step edge case, and that a duty change in the middle of a period leaves the pulse under way intact.

// File: rtl/fan_pwm.sv
module fan_pwm #(
  parameter int unsigned FAST_A = 3,
  parameter int unsigned FAST_B = 2,
  parameter int unsigned SLOW_A = 12,
  parameter int unsigned SLOW_B = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       force_i,
  input  logic       mult_i,
  input  logic       src_i,
  input  logic       sel_i,
  input  logic [5:0] duty_i,
  output logic       pwm_o
);
  localparam int unsigned MF   = (FAST_A > FAST_B) ? FAST_A : FAST_B;
  localparam int unsigned MS   = (SLOW_A > SLOW_B) ? SLOW_A : SLOW_B;
  localparam int unsigned DMAX = 2 * ((MF > MS) ? MF : MS);
  localparam int unsigned PW   = $clog2(DMAX + 1);

  logic [5:0]    cnt, duty_q;
  logic          mult_q, src_q, sel_q;
  logic [PW-1:0] pre, base, div;

  always_comb begin
    case ({src_q, sel_q})
      2'b00:   base = PW'(FAST_A);
      2'b01:   base = PW'(FAST_B);
      2'b10:   base = PW'(SLOW_A);
      default: base = PW'(SLOW_B);
    endcase
    div = mult_q ? base : (base << 1);
  end

  wire tick = (pre == div - PW'(1));
  wire wrap = tick && (cnt == 6'd63);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre    <= '0;
      cnt    <= '0;
      duty_q <= '0;
      mult_q <= 1'b0;
      src_q  <= 1'b0;
      sel_q  <= 1'b0;
    end else begin
      pre <= tick ? '0 : pre + PW'(1);
      if (tick) cnt <= cnt + 6'd1;
      if (wrap) begin
        duty_q <= duty_i;
        mult_q <= mult_i;
        src_q  <= src_i;
        sel_q  <= sel_i;
      end
    end
  end

  assign pwm_o = force_i | (cnt < duty_q);

  a_r4_step_advance: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> cnt == $past(cnt) + 6'd1);
  a_r4_step_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt));
  a_r5_pre_bound: assert property (@(posedge clk) disable iff (!rst_n)
    pre < div);
  a_r7_deferred: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(duty_q) && $stable({mult_q, src_q, sel_q}));
  a_r8_force_high: assert property (@(posedge clk) disable iff (!rst_n)
    force_i |-> pwm_o);
  a_r2_zero_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!force_i && duty_q == 6'd0) |-> !pwm_o);
endmodule

// File: tb/fan_pwm_tb.sv
module fan_pwm_tb;
  localparam int FA = 3, FB = 2, SA = 12, SB = 8;

  logic clk = 0, rst_n = 0, force_i = 0, mult_i = 0, src_i = 0, sel_i = 0;
  logic [5:0] duty_i = 0;
  logic pwm_o;
  int checks = 0, errors = 0, cyc = 0;

  fan_pwm #(.FAST_A(FA), .FAST_B(FB), .SLOW_A(SA), .SLOW_B(SB)) u_dut (
    .clk(clk), .rst_n(rst_n), .force_i(force_i), .mult_i(mult_i),
    .src_i(src_i), .sel_i(sel_i), .duty_i(duty_i), .pwm_o(pwm_o));

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles, expected < 190000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int divof(logic m, logic s, logic l);
    int b;
    b = s ? (l ? SB : SA) : (l ? FB : FA);
    return m ? b : 2 * b;
  endfunction

  task automatic measure(output int hi, output int lo);
    int g;
    hi = 0; lo = 0; g = 0;
    @(negedge clk);
    while (pwm_o && g < 20000) begin g++; @(negedge clk); end
    while (!pwm_o && g < 20000) begin g++; @(negedge clk); end
    while (pwm_o && g < 20000) begin hi++; g++; @(negedge clk); end
    while (!pwm_o && g < 20000) begin lo++; g++; @(negedge clk); end
  endtask

  task automatic settle();
    repeat (3300) @(negedge clk);
  endtask

  task automatic t_reset();
    int bad = 0;
    repeat (3) @(negedge clk) if (pwm_o) bad++;
    rst_n = 1;
    repeat (100) @(negedge clk) if (pwm_o) bad++;
    chk("R1 reset low", bad, 0);
  endtask

  task automatic t_zero();
    int bad = 0;
    duty_i = 0; mult_i = 1; src_i = 0; sel_i = 0;
    settle();
    repeat (500) @(negedge clk) if (pwm_o) bad++;
    chk("R2 zero duty low", bad, 0);
  endtask

  task automatic t_mode(logic m, logic s, logic l, logic [5:0] n);
    int hi, lo, d;
    duty_i = n; mult_i = m; src_i = s; sel_i = l;
    d = divof(m, s, l);
    settle();
    measure(hi, lo);
    chk(m ? "R3 R6 high time" : "R3 R5 high time", hi, n * d);
    chk(m ? "R4 R6 period" : "R4 R5 period", hi + lo, 64 * d);
  endtask

  task automatic t_full();
    int hi, lo;
    duty_i = 63; mult_i = 1; src_i = 0; sel_i = 1;
    settle();
    measure(hi, lo);
    chk("R9 one low step", lo, FB);
    chk("R9 high steps", hi, 63 * FB);
  endtask

  task automatic t_force();
    int bad = 0;
    duty_i = 0; mult_i = 0; src_i = 1; sel_i = 0;
    settle();
    force_i = 1;
    repeat (300) @(negedge clk) if (!pwm_o) bad++;
    chk("R8 forced high", bad, 0);
    force_i = 0;
    @(negedge clk);
    chk("R8 release", pwm_o, 0);
  endtask

  task automatic t_defer();
    int n = 0, hi, lo, g = 0;
    duty_i = 32; mult_i = 1; src_i = 0; sel_i = 0;
    settle();
    @(negedge clk);
    while (pwm_o && g < 20000) begin g++; @(negedge clk); end
    while (!pwm_o && g < 20000) begin g++; @(negedge clk); end
    while (pwm_o && g < 20000) begin
      n++; g++;
      if (n == 5) duty_i = 1;
      @(negedge clk);
    end
    chk("R7 pulse kept", n, 32 * FA);
    measure(hi, lo);
    chk("R7 next period new duty", hi, FA);
  endtask

  initial begin
    t_reset();
    t_zero();
    t_mode(0, 0, 0, 20);
    t_mode(0, 0, 1, 40);
    t_mode(0, 1, 0, 10);
    t_mode(0, 1, 1, 50);
    t_mode(1, 0, 0, 1);
    t_mode(1, 0, 1, 33);
    t_mode(1, 1, 0, 7);
    t_mode(1, 1, 1, 60);
    t_full();
    t_force();
    t_defer();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule